// File: doc/BRIEF.md
# Multiplexed Seven-Segment Display Scanner

This block drives a bank of four common-cathode seven-segment digits that share one segment bus. Each digit has its own cathode select line. The block holds four 8-bit segment patterns, loaded through a simple write port, and shows them one digit at a time. It steps through the digits in a fixed ring order, so that at the refresh rate the eye sees all four lit at once. It decodes nothing. Each pattern goes to the bus bit for bit, so the logic that writes the patterns chooses which segments and decimal points light.

Each digit owns one time slot of `DWELL_CYCLES` clocks. At the start of a slot every cathode is driven high. The new digit's pattern is then placed on the segment bus and held for `BLANK_CYCLES` clocks with the bank still dark. Only after that does the digit's cathode go low for the rest of the slot. This order keeps the last code of one digit from flashing on its neighbour. For a steady image, `DWELL_CYCLES` is normally set to about one millisecond of clock. The parameters must satisfy `BLANK_CYCLES >= 1` and `DWELL_CYCLES >= BLANK_CYCLES + 2`.

Top module: `seg_scan_top`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears its state. After that edge `cath_o` is 4'b1111, `seg_o` is 8'h00, and the scan restarts at digit 0.
- R2: In no cycle is more than one bit of `cath_o` low. In every lit cycle of a slot, exactly one bit is low.
- R3: `seg_o` is active high and carries the stored pattern unchanged: bit 0 is segment a, bits 1 to 6 are segments b to g, and bit 7 is the decimal point.
- R4: Digit k is lit by driving `cath_o[k]` low. The digits are visited in the order 0, 1, 2, 3 and then 0 again, without end.
- R5: A slot lasts `DWELL_CYCLES` clocks, counted by a phase count p from 0. At p = 0 all cathodes are high and `seg_o` still holds the previous code. For p = 1 to `BLANK_CYCLES`, all cathodes stay high and `seg_o` holds the new digit's code. For the remaining cycles of the slot, that digit's cathode is low.
- R6: When a cathode goes low, `seg_o` has already held the same code for the cycle before. `seg_o` does not change while any cathode is low.
- R7: A write with `wr_en` high stores `wr_data` as the pattern for digit `wr_addr`. A write to the digit now lit leaves `seg_o` unchanged until that digit's next slot, which then shows the new pattern.
- R8: A write to digit k made in the same cycle that digit k's slot starts (p = 0) is the pattern shown in that slot.
- R9: Reset clears all four patterns to 8'h00, and a write made while `rst` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Pattern write strobe |
| wr_addr | input | 2 | Digit index written |
| wr_data | input | 8 | Segment pattern; bit 0 = a, bits 1 to 6 = b to g, bit 7 = decimal point |
| seg_o | output | 8 | Segment bus, active high |
| cath_o | output | 4 | Cathode selects, active low, one per digit |

## Verification
The main scan is tried with several sets of patterns: all-distinct values, single-bit values, all-ones, and a repeated value across digits. These tell a true per-digit mapping apart from an index swap, a bit reversal or a stuck segment line. Writes are timed against the scan in three ways: a write to the digit now lit, a write on the very cycle its slot opens, and a write while reset is high. These separate the snapshot-at-slot-start behaviour from a design that passes writes straight through, or that takes a same-cycle write one slot late. A cycle-accurate model of the slot phases is compared against the outputs on every cycle. A direct trace of the lit digit over eight slots checks the ring order and the wrap from digit 3 to digit 0.

// File: rtl/dscan_pkg.sv
package dscan_pkg;

    localparam int SEG_W  = 8;
    localparam int DIGITS = 4;
    localparam int IDX_W  = $clog2(DIGITS);

    typedef logic [SEG_W-1:0]  seg_pat_t;
    typedef logic [IDX_W-1:0]  dig_idx_t;
    typedef logic [DIGITS-1:0] cath_t;

    typedef struct packed {
        logic     en;
        dig_idx_t addr;
        seg_pat_t data;
    } pat_wr_t;

    // Phase within one digit slot
    typedef enum logic [1:0] {
        PH_SWAP   = 2'd0,  // bank dark, new code being fetched
        PH_SETTLE = 2'd1,  // bank dark, new code on the bus
        PH_LIT    = 2'd2   // selected digit driven
    } slot_phase_e;

    function automatic cath_t cathode_select(dig_idx_t i);
        return ~(cath_t'(1) << i);
    endfunction

    function automatic dig_idx_t next_digit(dig_idx_t i);
        if (int'(i) == DIGITS - 1)
            return '0;
        return i + dig_idx_t'(1);
    endfunction

endpackage

// File: rtl/dscan_pattern_bank.sv
module dscan_pattern_bank
    import dscan_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  pat_wr_t  wr_i,
    input  dig_idx_t rd_idx_i,
    output seg_pat_t rd_data_o
);

    seg_pat_t regs_q [DIGITS];

    for (genvar g = 0; g < DIGITS; g++) begin : g_digit
        always_ff @(posedge clk) begin
            if (rst)
                regs_q[g] <= '0;
            else if (wr_i.en && (int'(wr_i.addr) == g))
                regs_q[g] <= wr_i.data;
        end
    end

    // Same-cycle write to the digit being fetched is forwarded (R8)
    always_comb begin
        if (wr_i.en && (wr_i.addr == rd_idx_i))
            rd_data_o = wr_i.data;
        else
            rd_data_o = regs_q[rd_idx_i];
    end

endmodule

// File: rtl/dscan_timer.sv
module dscan_timer
    import dscan_pkg::*;
#(
    parameter  int DWELL_CYCLES = 250000,
    parameter  int BLANK_CYCLES = 4,
    localparam int CNT_W        = $clog2(DWELL_CYCLES)
) (
    input  logic        clk,
    input  logic        rst,
    output dig_idx_t    idx_o,
    output slot_phase_e phase_o
);

    logic [CNT_W-1:0] cnt_q;
    dig_idx_t         idx_q;
    logic             slot_end;

    assign slot_end = (cnt_q == CNT_W'(DWELL_CYCLES - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            idx_q <= '0;
        end else if (slot_end) begin
            cnt_q <= '0;
            idx_q <= next_digit(idx_q);
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    always_comb begin
        if (cnt_q == '0)
            phase_o = PH_SWAP;
        else if (cnt_q <= CNT_W'(BLANK_CYCLES))
            phase_o = PH_SETTLE;
        else
            phase_o = PH_LIT;
    end

    assign idx_o = idx_q;

    // R4: digit index only ever steps to its ring successor
    p_ring_order_r4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && idx_q != $past(idx_q)) |-> idx_q == next_digit($past(idx_q)));

    // R5: a digit change follows the last count of a full slot
    p_slot_length_r5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && idx_q != $past(idx_q)) |-> $past(cnt_q) == CNT_W'(DWELL_CYCLES - 1));

endmodule

// File: rtl/dscan_digit_driver.sv
module dscan_digit_driver
    import dscan_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  slot_phase_e phase_i,
    input  dig_idx_t    idx_i,
    input  seg_pat_t    pat_i,
    output seg_pat_t    seg_o,
    output cath_t       cath_o
);

    seg_pat_t shown_q;

    // Snapshot taken once per slot, so writes never disturb a lit digit
    always_ff @(posedge clk) begin
        if (rst)
            shown_q <= '0;
        else if (phase_i == PH_SWAP)
            shown_q <= pat_i;
    end

    assign seg_o  = shown_q;
    assign cath_o = (phase_i == PH_LIT) ? cathode_select(idx_i) : '1;

    // R2: never two digits driven together
    p_one_cold_r2: assert property (@(posedge clk) disable iff (rst)
        $countones(~cath_o) <= 1);

    // R6: bus code is settled and held whenever a cathode is low
    p_code_settled_r6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && cath_o != '1) |-> $stable(seg_o));

endmodule

// File: rtl/seg_scan_top.sv
module seg_scan_top
    import dscan_pkg::*;
#(
    parameter int DWELL_CYCLES = 250000,
    parameter int BLANK_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_addr,
    input  logic [SEG_W-1:0]  wr_data,
    output logic [SEG_W-1:0]  seg_o,
    output logic [DIGITS-1:0] cath_o
);

    pat_wr_t     wr;
    dig_idx_t    idx;
    slot_phase_e phase;
    seg_pat_t    fetched;

    assign wr = '{en: wr_en, addr: wr_addr, data: wr_data};

    dscan_timer #(
        .DWELL_CYCLES (DWELL_CYCLES),
        .BLANK_CYCLES (BLANK_CYCLES)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .idx_o   (idx),
        .phase_o (phase)
    );

    dscan_pattern_bank u_bank (
        .clk       (clk),
        .rst       (rst),
        .wr_i      (wr),
        .rd_idx_i  (idx),
        .rd_data_o (fetched)
    );

    dscan_digit_driver u_drv (
        .clk     (clk),
        .rst     (rst),
        .phase_i (phase),
        .idx_i   (idx),
        .pat_i   (fetched),
        .seg_o   (seg_o),
        .cath_o  (cath_o)
    );

    // R5: the bank is dark in the first cycle of every new slot
    p_dark_on_change_r5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && idx != $past(idx)) |-> cath_o == '1);

endmodule

// File: tb/tb_seg_scan_top.sv
`timescale 1ns/1ps
module tb_seg_scan_top;

    localparam int DW = 8;
    localparam int BL = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] seg_o;
    logic [3:0] cath_o;

    int total = 0;
    int bad = 0;
    bit done = 0;
    bit mon_on = 0;

    seg_scan_top #(.DWELL_CYCLES(DW), .BLANK_CYCLES(BL)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .seg_o(seg_o), .cath_o(cath_o)
    );

    always #2 clk = ~clk;

    // Reference of the slot schedule, built from R1, R4, R5, R7, R8, R9
    int         m_cnt = 0;
    int         m_idx = 0;
    logic [7:0] m_shown = '0;
    logic [7:0] m_pat [4] = '{default: 8'h00};

    always @(posedge clk) begin
        if (rst) begin
            m_cnt <= 0;
            m_idx <= 0;
            m_shown <= '0;
            for (int i = 0; i < 4; i++) m_pat[i] <= '0;
        end else begin
            if (wr_en) m_pat[wr_addr] <= wr_data;
            if (m_cnt == 0)
                m_shown <= (wr_en && int'(wr_addr) == m_idx) ? wr_data : m_pat[m_idx];
            if (m_cnt == DW - 1) begin
                m_cnt <= 0;
                m_idx <= (m_idx + 1) % 4;
            end else begin
                m_cnt <= m_cnt + 1;
            end
        end
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    logic [7:0] prev_seg;
    logic [3:0] prev_cath;

    // Per-cycle comparison, sampled on the falling edge
    always @(negedge clk) begin
        if (mon_on && !rst) begin
            chk("R3/R7 seg", seg_o, m_shown);
            chk("R4/R5 cath", {4'h0, cath_o},
                {4'h0, (m_cnt > BL) ? ~(4'b0001 << m_idx) : 4'b1111});
            chk("R2 one cold", {7'h0, ($countones(~cath_o) <= 1)}, 8'h01);
            if (prev_cath == 4'hF && cath_o != 4'hF)
                chk("R6 code before enable", seg_o, prev_seg);
        end
        prev_seg  = seg_o;
        prev_cath = cath_o;
    end

    // Stimulus table: {digit, pattern}
    localparam logic [9:0] VEC [8] = '{
        {2'd0, 8'h3F}, {2'd1, 8'h06}, {2'd2, 8'h5B}, {2'd3, 8'hCF},
        {2'd3, 8'h01}, {2'd0, 8'h80}, {2'd1, 8'hFF}, {2'd2, 8'h01}
    };

    task automatic write_pat(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        #400000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] old_v;
        int k;
        int first;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 cath in reset", {4'h0, cath_o}, 8'h0F);
        chk("R1 seg in reset", seg_o, 8'h00);
        rst = 1'b0;
        mon_on = 1'b1;

        // R3 / R7: walk the table, one full scan after each group of four
        for (int i = 0; i < 8; i++) begin
            write_pat(VEC[i][9:8], VEC[i][7:0]);
            if (i % 4 == 3) repeat (4 * DW + 2) @(negedge clk);
        end

        // R4: trace of lit digit over eight slots
        while (m_cnt != BL + 1) @(negedge clk);
        first = m_idx;
        for (int n = 0; n < 8; n++) begin
            while (m_cnt != BL + 1) @(negedge clk);
            k = -1;
            for (int b = 0; b < 4; b++) if (!cath_o[b]) k = b;
            chk("R4 ring order", 8'(k), 8'((first + n) % 4));
            @(negedge clk);
        end

        // R7: write to the lit digit holds until its next slot
        while (m_cnt != BL + 2) @(negedge clk);
        old_v = seg_o;
        k = m_idx;
        write_pat(2'(k), 8'hA5);
        chk("R7 lit digit unchanged", seg_o, old_v);
        while (m_idx == k) @(negedge clk);
        while (!(m_idx == k && m_cnt == 1)) @(negedge clk);
        chk("R7 new pattern next visit", seg_o, 8'hA5);

        // R8: write on the slot-start cycle is shown in that slot
        while (m_cnt != 0) @(negedge clk);
        k = m_idx;
        write_pat(2'(k), 8'h5A);
        chk("R8 same-cycle write shown", seg_o, 8'h5A);
        repeat (4 * DW) @(negedge clk);

        // R9 / R1: reset mid-scan with a write during reset
        while (m_cnt != BL + 3) @(negedge clk);
        rst = 1'b1;
        write_pat(2'd0, 8'h77);
        @(negedge clk);
        chk("R1 cath after mid-scan reset", {4'h0, cath_o}, 8'h0F);
        chk("R1 seg after mid-scan reset", seg_o, 8'h00);
        rst = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R1 restart at digit 0 code", seg_o, 8'h00);
        while (m_cnt != BL + 1) @(negedge clk);
        chk("R1 restart lights digit 0", {4'h0, cath_o}, 8'h0E);
        repeat (4 * DW) begin
            @(negedge clk);
            chk("R9 patterns cleared", seg_o, 8'h00);
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule